// File: doc/BRIEF.md
# ISDN Terminal Layer-1 Activation Controller

This block tracks the activation state of the terminal side of an ISDN S/T line. Layer 1 hardware reports the line condition as a 4-bit indication nibble, qualified by a one-cycle valid strobe. Layer 2 asks for activation with a request pulse. An internal supervision timer limits how long an activation attempt may take. From these three event sources the block walks a nine-state machine: a reset state, three variants of F3 (power-down, power-up and pending deactivation), then F4 through F8.

Each accepted event may cause one or more actions. The block can put out a 4-bit command nibble with a one-cycle strobe, pulse an activate or deactivate indication toward layer 2, and start or cancel the timer. A level output is high while the line is fully active. Layer 2 uses it to gate transmission of data.

Top module: `l1_act_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the machine is in the reset state. `cmd_valid`, `cmd_code`, `act_ind`, `deact_ind` and `link_active` are all 0 until an event acts.
- R2: Indication RES (0001) or EI (0110) in any state moves the machine to the reset state and issues command DI (1111). When the move is out of F7, `deact_ind` is also pulsed.
- R3: Indication AI8 (1100) in any state other than F7 or F3 power-up moves the machine to F7. It cancels the supervision timer, issues command AR8 (1000) and pulses `act_ind`. `link_active` is high exactly while the state is F7.
- R4: Indication DC (1111) moves the machine to F3 power-down from reset, F3 pending, F4, F5, F6 and F8. Indication AR (1000) moves it to F6 from reset, F3 power-down, F3 pending, F5 and F8. None of these moves issues a command or an indication.
- R5: Indication RSY (0100) moves the machine to F5 from F3 power-down, F3 pending and F4, and to F8 from F6. Indication PU (0111) moves it from F3 power-down to F4. None of these moves issues a command.
- R6: Indication DR (0000) in F5 or F8, and indication DR6 (0101) in F6, move the machine to F3 pending and issue DI, with no layer-2 indication.
- R7: In F7, AR moves to F6, RSY moves to F8 and DR moves to F3 pending, and each pulses `deact_ind`. Only the DR case issues DI.
- R8: `act_req` in F3 power-down issues AR8 and restarts the timer for `TMR_CYCLES` cycles. The expiry is processed `TMR_CYCLES` cycles after the AR8 strobe. In F3 power-down, F4, F5, F6 or F8 the expiry issues DI and pulses `deact_ind`, and the state does not change. The timer fires once per start.
- R9: Any pair of state and event not named in R2 to R8 changes nothing and issues nothing. This includes the unused indication codes, `act_req` outside F3 power-down, an expiry in the reset state, F3 pending or F7, and every `deact_req`.
- R10: Only one event acts per cycle. A valid indication takes precedence over a timer expiry, and an expiry takes precedence over `act_req`. A lower-priority event in the same cycle is discarded, and a discarded expiry is lost.
- R11: Commands and indications are registered one-cycle pulses that appear in the cycle after the event. `act_ind` and `deact_ind` are never high together. `cmd_code` is 0 whenever `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_valid | input | 1 | Indication nibble strobe |
| ind_code | input | 4 | Indication nibble from layer 1 |
| act_req | input | 1 | Activate request pulse from layer 2 |
| deact_req | input | 1 | Deactivate request pulse from layer 2 (no effect) |
| cmd_valid | output | 1 | Command nibble strobe |
| cmd_code | output | 4 | Command nibble toward layer 1 |
| act_ind | output | 1 | Activate indication pulse to layer 2 |
| deact_ind | output | 1 | Deactivate indication pulse to layer 2 |
| link_active | output | 1 | High while the line is fully active (F7) |

## Verification
The bench builds the controller with `TMR_CYCLES` set to 20 rather than the long default. This lets a supervision timeout fire many times during both the directed activation attempts and the random run. It therefore covers expiries in every state where they act, expiries in states where they are ignored, and expiries that lose to a simultaneous indication. The short period also keeps restart-after-expiry sequences within a few hundred cycles, so the random mix of indications and requests reaches every edge of the transition table.

// File: rtl/l1_act_pkg.sv
package l1_act_pkg;

  typedef enum logic [3:0] {
    ST_RST     = 4'd0,
    ST_F3_PDN  = 4'd1,
    ST_F3_PUP  = 4'd2,
    ST_F3_PEND = 4'd3,
    ST_F4      = 4'd4,
    ST_F5      = 4'd5,
    ST_F6      = 4'd6,
    ST_F7      = 4'd7,
    ST_F8      = 4'd8
  } l1_state_e;

  localparam int unsigned CODE_W = 4;

  // indication nibbles from layer 1
  localparam logic [CODE_W-1:0] IND_DR  = 4'h0;
  localparam logic [CODE_W-1:0] IND_RES = 4'h1;
  localparam logic [CODE_W-1:0] IND_RSY = 4'h4;
  localparam logic [CODE_W-1:0] IND_DR6 = 4'h5;
  localparam logic [CODE_W-1:0] IND_EI  = 4'h6;
  localparam logic [CODE_W-1:0] IND_PU  = 4'h7;
  localparam logic [CODE_W-1:0] IND_AR  = 4'h8;
  localparam logic [CODE_W-1:0] IND_AI8 = 4'hC;
  localparam logic [CODE_W-1:0] IND_DC  = 4'hF;

  // command nibbles toward layer 1
  localparam logic [CODE_W-1:0] CMD_AR8 = 4'h8;
  localparam logic [CODE_W-1:0] CMD_DI  = 4'hF;

endpackage

// File: rtl/l1_act_timer.sv
module l1_act_timer #(
  parameter int unsigned TMR_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cancel_i,
  output logic expire_o
);

  localparam int unsigned CW = (TMR_CYCLES > 1) ? $clog2(TMR_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(TMR_CYCLES - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    expire_o = run_q && (cnt_q == '0);
    run_d    = run_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (cancel_i) begin
      run_d = 1'b0;
    end else if (start_i) begin
      run_d  = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // the count never leaves the loaded window
  assert_cnt_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= LOAD));

  // one start gives a single expiry pulse
  assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !start_i) |=> !expire_o);

endmodule

// File: rtl/l1_act_fsm.sv
module l1_act_fsm
  import l1_act_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ind_valid,
  input  logic [CODE_W-1:0] ind_code,
  input  logic              act_req,
  input  logic              tmr_expire,
  output logic              tmr_start,
  output logic              tmr_cancel,
  output logic              cmd_valid,
  output logic [CODE_W-1:0] cmd_code,
  output logic              act_ind,
  output logic              deact_ind,
  output logic              link_active
);

  l1_state_e         state_q, state_d;
  logic              cv_d, ai_d, di_d;
  logic [CODE_W-1:0] cc_d;

  always_comb begin
    state_d    = state_q;
    cv_d       = 1'b0;
    cc_d       = '0;
    ai_d       = 1'b0;
    di_d       = 1'b0;
    tmr_start  = 1'b0;
    tmr_cancel = 1'b0;
    if (ind_valid) begin
      case (ind_code)
        IND_RES, IND_EI: begin
          state_d = ST_RST;
          cv_d    = 1'b1;
          cc_d    = CMD_DI;
          di_d    = (state_q == ST_F7);
        end
        IND_AI8: begin
          if (state_q != ST_F7 && state_q != ST_F3_PUP) begin
            state_d    = ST_F7;
            tmr_cancel = 1'b1;
            cv_d       = 1'b1;
            cc_d       = CMD_AR8;
            ai_d       = 1'b1;
          end
        end
        IND_DC: begin
          if (state_q inside {ST_RST, ST_F3_PEND, ST_F4, ST_F5, ST_F6, ST_F8})
            state_d = ST_F3_PDN;
        end
        IND_AR: begin
          if (state_q inside {ST_RST, ST_F3_PDN, ST_F3_PEND, ST_F5, ST_F8}) begin
            state_d = ST_F6;
          end else if (state_q == ST_F7) begin
            state_d = ST_F6;
            di_d    = 1'b1;
          end
        end
        IND_RSY: begin
          if (state_q inside {ST_F3_PDN, ST_F3_PEND, ST_F4}) begin
            state_d = ST_F5;
          end else if (state_q == ST_F6) begin
            state_d = ST_F8;
          end else if (state_q == ST_F7) begin
            state_d = ST_F8;
            di_d    = 1'b1;
          end
        end
        IND_PU: begin
          if (state_q == ST_F3_PDN) state_d = ST_F4;
        end
        IND_DR: begin
          if (state_q inside {ST_F5, ST_F8, ST_F7}) begin
            state_d = ST_F3_PEND;
            cv_d    = 1'b1;
            cc_d    = CMD_DI;
            di_d    = (state_q == ST_F7);
          end
        end
        IND_DR6: begin
          if (state_q == ST_F6) begin
            state_d = ST_F3_PEND;
            cv_d    = 1'b1;
            cc_d    = CMD_DI;
          end
        end
        default: ;
      endcase
    end else if (tmr_expire) begin
      if (state_q inside {ST_F3_PDN, ST_F4, ST_F5, ST_F6, ST_F8}) begin
        cv_d = 1'b1;
        cc_d = CMD_DI;
        di_d = 1'b1;
      end
    end else if (act_req && state_q == ST_F3_PDN) begin
      tmr_start = 1'b1;
      cv_d      = 1'b1;
      cc_d      = CMD_AR8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RST;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      act_ind   <= 1'b0;
      deact_ind <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_valid <= cv_d;
      cmd_code  <= cc_d;
      act_ind   <= ai_d;
      deact_ind <= di_d;
    end
  end

  assign link_active = (state_q == ST_F7);

  assert_ai_with_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_ind |-> link_active);

  assert_link_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_active) |-> (act_ind && cmd_valid && cmd_code == CMD_AR8));

  assert_link_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_active) |-> deact_ind);

  assert_ind_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_ind && deact_ind));

  assert_cmd_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code == CMD_DI || cmd_code == CMD_AR8));

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ind_valid && !tmr_expire && !act_req) |=> (!cmd_valid && $stable(state_q)));

endmodule

// File: rtl/l1_act_ctrl.sv
module l1_act_ctrl
  import l1_act_pkg::*;
#(
  parameter int unsigned TMR_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ind_valid,
  input  logic [3:0] ind_code,
  input  logic       act_req,
  input  logic       deact_req,
  output logic       cmd_valid,
  output logic [3:0] cmd_code,
  output logic       act_ind,
  output logic       deact_ind,
  output logic       link_active
);

  logic tmr_start, tmr_cancel, tmr_expire;
  logic deact_req_unused;

  // deactivation is driven by the line only; the request has no effect
  assign deact_req_unused = deact_req;

  l1_act_timer #(
    .TMR_CYCLES(TMR_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (tmr_start),
    .cancel_i (tmr_cancel),
    .expire_o (tmr_expire)
  );

  l1_act_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ind_valid   (ind_valid),
    .ind_code    (ind_code),
    .act_req     (act_req),
    .tmr_expire  (tmr_expire),
    .tmr_start   (tmr_start),
    .tmr_cancel  (tmr_cancel),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .act_ind     (act_ind),
    .deact_ind   (deact_ind),
    .link_active (link_active)
  );

endmodule

// File: tb/l1_act_ctrl_tb.sv
module l1_act_ctrl_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned TMR = 20;

  localparam int S_RST = 0, S_PDN = 1, S_PUP = 2, S_PEND = 3,
                 S_F4 = 4, S_F5 = 5, S_F6 = 6, S_F7 = 7, S_F8 = 8;

  logic       clk;
  logic       rst_n;
  logic       ind_valid;
  logic [3:0] ind_code;
  logic       act_req;
  logic       deact_req;
  logic       cmd_valid;
  logic [3:0] cmd_code;
  logic       act_ind;
  logic       deact_ind;
  logic       link_active;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  // reference model state
  int    m_state;
  bit    mt_run;
  int    mt_cnt;
  bit    e_cv, e_ai, e_di, e_link;
  bit [3:0] e_cc;
  string tag;

  l1_act_ctrl #(.TMR_CYCLES(TMR)) u_dut (
    .clk(clk), .rst_n(rst_n), .ind_valid(ind_valid), .ind_code(ind_code),
    .act_req(act_req), .deact_req(deact_req), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .act_ind(act_ind), .deact_ind(deact_ind),
    .link_active(link_active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit in_set(int s, int a, int b, int c, int d, int e, int f);
    return (s == a) || (s == b) || (s == c) || (s == d) || (s == e) || (s == f);
  endfunction

  task automatic model_step(bit iv, bit [3:0] ic, bit ar);
    bit fire = mt_run && (mt_cnt == 0);
    bit start = 0;
    bit cancel = 0;
    int s = m_state;
    e_cv = 0; e_cc = 4'h0; e_ai = 0; e_di = 0;
    tag = "R9";
    if (iv) begin
      case (ic)
        4'h1, 4'h6: begin
          tag = "R2"; m_state = S_RST; e_cv = 1; e_cc = 4'hF; e_di = (s == S_F7);
        end
        4'hC: if (s != S_F7 && s != S_PUP) begin
          tag = "R3"; m_state = S_F7; cancel = 1; e_cv = 1; e_cc = 4'h8; e_ai = 1;
        end
        4'hF: if (in_set(s, S_RST, S_PEND, S_F4, S_F5, S_F6, S_F8)) begin
          tag = "R4"; m_state = S_PDN;
        end
        4'h8: if (in_set(s, S_RST, S_PDN, S_PEND, S_F5, S_F8, S_F8)) begin
          tag = "R4"; m_state = S_F6;
        end else if (s == S_F7) begin
          tag = "R7"; m_state = S_F6; e_di = 1;
        end
        4'h4: if (in_set(s, S_PDN, S_PEND, S_F4, S_F4, S_F4, S_F4)) begin
          tag = "R5"; m_state = S_F5;
        end else if (s == S_F6) begin
          tag = "R5"; m_state = S_F8;
        end else if (s == S_F7) begin
          tag = "R7"; m_state = S_F8; e_di = 1;
        end
        4'h7: if (s == S_PDN) begin
          tag = "R5"; m_state = S_F4;
        end
        4'h0: if (s == S_F5 || s == S_F8) begin
          tag = "R6"; m_state = S_PEND; e_cv = 1; e_cc = 4'hF;
        end else if (s == S_F7) begin
          tag = "R7"; m_state = S_PEND; e_cv = 1; e_cc = 4'hF; e_di = 1;
        end
        4'h5: if (s == S_F6) begin
          tag = "R6"; m_state = S_PEND; e_cv = 1; e_cc = 4'hF;
        end
        default: ;
      endcase
      if (fire || ar) tag = {tag, "/R10"};
    end else if (fire) begin
      if (in_set(s, S_PDN, S_F4, S_F5, S_F6, S_F8, S_F8)) begin
        tag = "R8"; e_cv = 1; e_cc = 4'hF; e_di = 1;
      end
      if (ar) tag = {tag, "/R10"};
    end else if (ar && s == S_PDN) begin
      tag = "R8"; start = 1; e_cv = 1; e_cc = 4'h8;
    end
    if (e_cv) tag = {tag, "/R11"};
    // supervision timer: fires TMR cycles after its start is processed
    if (cancel) mt_run = 0;
    else if (start) begin mt_run = 1; mt_cnt = TMR - 1; end
    else if (mt_run) begin
      if (mt_cnt == 0) mt_run = 0; else mt_cnt = mt_cnt - 1;
    end
    e_link = (m_state == S_F7);
  endtask

  task automatic check_out(string t, bit [7:0] exp);
    bit [7:0] got = {cmd_valid, cmd_code, act_ind, deact_ind, link_active};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, got, exp);
    end
  endtask

  task automatic cycle(bit iv, bit [3:0] ic, bit ar, bit dr);
    ind_valid = iv; ind_code = ic; act_req = ar; deact_req = dr;
    model_step(iv, ic, ar);
    @(posedge clk);
    @(negedge clk);
    check_out(tag, {e_cv, e_cc, e_ai, e_di, e_link});
  endtask

  function automatic bit [3:0] pick_code();
    int r = $urandom % 12;
    case (r)
      0: return 4'h0;  1: return 4'h1;  2: return 4'h4;
      3: return 4'h5;  4: return 4'h6;  5: return 4'h7;
      6: return 4'h8;  7: return 4'hC;  8: return 4'hF;
      9: return 4'hC;  10: return 4'h4;
      default: return 4'($urandom % 16);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51C0_7A3B));
    rst_n = 1'b0; ind_valid = 0; ind_code = 0; act_req = 0; deact_req = 0;
    m_state = S_RST; mt_run = 0; mt_cnt = 0;
    repeat (3) @(negedge clk);
    check_out("R1", 8'h00);                  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1", 8'h00);                  // R1 after release

    // directed: activation attempt that times out (R4, R8)
    cycle(1, 4'hF, 0, 0);                    // DC: reset -> F3 power-down
    cycle(0, 4'h0, 1, 0);                    // activate request -> AR8
    for (int i = 0; i < TMR + 2; i++) cycle(0, 4'h0, 0, 0);
    // retry, then full activation (R5, R3)
    cycle(0, 4'h0, 1, 0);
    cycle(1, 4'h7, 0, 0);                    // PU -> F4
    cycle(1, 4'hC, 0, 0);                    // AI8 -> F7, timer cancelled
    for (int i = 0; i < TMR + 2; i++) cycle(0, 4'h0, 0, 0);
    cycle(1, 4'h7, 0, 0);                    // R9 PU ignored in F7
    cycle(0, 4'h0, 1, 1);                    // R9 requests ignored in F7
    cycle(1, 4'h8, 0, 0);                    // R7 AR: F7 -> F6
    cycle(1, 4'h4, 0, 0);                    // R5 RSY: F6 -> F8
    cycle(1, 4'hC, 0, 0);                    // R3 back to F7
    cycle(1, 4'h4, 0, 0);                    // R7 RSY: F7 -> F8
    cycle(1, 4'h0, 0, 0);                    // R6 DR in F8
    cycle(1, 4'h4, 0, 0);                    // R5 pending -> F5
    cycle(1, 4'h0, 0, 0);                    // R6 DR in F5
    cycle(1, 4'h8, 0, 0);                    // R4 pending -> F6
    cycle(1, 4'h5, 0, 0);                    // R6 DR6 in F6
    cycle(1, 4'hC, 1, 0);                    // R10 AI8 beats act_req
    cycle(1, 4'h0, 0, 0);                    // R7 DR out of F7
    cycle(1, 4'hC, 0, 0);
    cycle(1, 4'h1, 0, 0);                    // R2 RES out of F7
    cycle(1, 4'h6, 0, 0);                    // R2 EI in reset
    // R10: expiry coinciding with an indication is lost
    cycle(1, 4'hF, 0, 0);
    cycle(0, 4'h0, 1, 0);
    for (int i = 0; i < TMR - 1; i++) cycle(0, 4'h0, 0, 0);
    cycle(1, 4'h2, 1, 0);
    for (int i = 0; i < 4; i++) cycle(0, 4'h0, 0, 0);

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      if (n % 300 == 299) begin
        for (int i = 0; i < TMR + 3; i++) cycle(0, 4'h0, 0, 0);
      end else begin
        cycle(($urandom % 3) == 0, pick_code(), ($urandom % 5) == 0,
              ($urandom % 7) == 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule